// File: doc/BRIEF.md
# Programmable Interval Timer with Programmable Interrupt Vector

This block is a per-processor interval timer on a small 32-bit register bus. Software first stops the timer, then stores a reload count in bus-clock cycles, then writes a control word. That word sets the run bit and also chooses the interrupt number and the priority the timer will raise. While it runs, the timer counts down once per clock. Each time the count expires, it emits a one-cycle interrupt request together with its vector and priority, reloads, and counts again. It keeps firing until software writes zero to the control word.

The interrupt number is not wired in. The parameter `MAP_MODE` selects how the programmed number turns into the vector the interrupt controller sees. In mode 0 the number passes through unchanged. In mode 1 the vector is confined to 64..127: the two top bits of the number are dropped, bit 6 is forced high, and the priority shifted left by two is ORed into the low bits. A read-only register reports the bus clock period in nanoseconds. That value is fixed by a parameter.

Top module: `ivtimer`

## Requirements
- R1: After reset the timer is stopped, `irq_req` is low, and reads of the control (0x00), reload (0x10) and count (0x14) registers return 0.
- R2: The control word at 0x00 holds the run bit at bit 26, a 4-bit priority at bits 23:20 and an 8-bit interrupt number at bits 19:12. All other bits are dropped on write and read back as zero. Writing the word with bit 26 clear does not start the timer.
- R3: The reload register at 0x10 reads back the full 32-bit value written. The period register at 0x18 always returns `BUS_PERIOD_NS`, and writes to it have no effect. `rdata` is combinational from `addr` while `rd_en` is high, and is zero otherwise.
- R4: Writing the control word with bit 26 set while the timer is stopped loads the count from the reload value. If that write is taken on clock edge A, with reload value T, `irq_req` is high after edges A+T, A+2T, and so on.
- R5: Each expiry gives an `irq_req` pulse of exactly one clock cycle. When the reload value is greater than 1, `irq_req` is low between pulses.
- R6: A reload value of 0 acts as 1, so the running timer requests an interrupt on every cycle.
- R7: Writing 0 to the control word stops the timer on that write's edge. No request is raised on that edge or afterwards, even on an edge where the count would have expired. The count holds its last value.
- R8: A reload value written while the timer runs leaves the current interval unchanged. It sets the length of the intervals that start at later reloads.
- R9: `irq_pri` equals the stored priority. In mode 0, `irq_vec` equals the stored number. In mode 1, `irq_vec` = 0x40 | (number & 0x3F) | (priority << 2).
- R10: Writing the control word with bit 26 set while the timer already runs does not restart the count. It only updates the vector and priority, which apply from that edge on.
- R11: While the timer runs, the count read at 0x14 drops by one each cycle, never reads 0, and after an expiry holds the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; the write is taken on the rising clock edge |
| rd_en | input | 1 | Read strobe; enables `rdata` |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq_req | output | 1 | One-cycle interrupt request at each expiry |
| irq_vec | output | 8 | Interrupt vector after mapping |
| irq_pri | output | 4 | Interrupt priority |

## Verification
The bench builds two copies of the block on the same bus. One uses `MAP_MODE` = 1 and the other `MAP_MODE` = 0, so every expected pulse checks both vector mappings on the same stimulus. Both use a 32-bit counter, which allows a full-width reload readback, and `BUS_PERIOD_NS` = 5 to match the bench clock. A short reload of 5 and then 3 keeps the pulse schedule short. This makes it possible to hit the exact edges where a reload change, a control rewrite and a stop request meet an expiry.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned EN_BIT  = 26;
    localparam int unsigned PRI_LSB = 20;
    localparam int unsigned PRI_W   = 4;
    localparam int unsigned NUM_LSB = 12;
    localparam int unsigned NUM_W   = 8;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_RELOAD = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_PERIOD = 8'h18;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_COUNT,
        SEL_PERIOD
    } reg_sel_e;

    typedef struct packed {
        logic             run;
        logic [PRI_W-1:0] pri;
        logic [NUM_W-1:0] num;
    } ctrl_t;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned BUS_PERIOD_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic              run_next,
    output logic [CNT_W-1:0]  reload,
    output logic [BUS_W-1:0]  rdata
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t    s_d, s_q;
    reg_sel_e sel;
    logic [BUS_W-1:0] ctrl_word;

    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_RELOAD)) sel = SEL_RELOAD;
        else if (addr == ADDR_W'(OFS_COUNT))  sel = SEL_COUNT;
        else if (addr == ADDR_W'(OFS_PERIOD)) sel = SEL_PERIOD;
        else                                  sel = SEL_NONE;
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    s_d.ctrl.run = wdata[EN_BIT];
                    s_d.ctrl.pri = wdata[PRI_LSB +: PRI_W];
                    s_d.ctrl.num = wdata[NUM_LSB +: NUM_W];
                end
                SEL_RELOAD: s_d.reload = wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[EN_BIT]            = s_q.ctrl.run;
        ctrl_word[PRI_LSB +: PRI_W]  = s_q.ctrl.pri;
        ctrl_word[NUM_LSB +: NUM_W]  = s_q.ctrl.num;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_CTRL:   rdata = ctrl_word;
                SEL_RELOAD: rdata = BUS_W'(s_q.reload);
                SEL_COUNT:  rdata = BUS_W'(cnt);
                SEL_PERIOD: rdata = BUS_W'(BUS_PERIOD_NS);
                default:    rdata = '0;
            endcase
        end
    end

    assign ctrl     = s_q.ctrl;
    assign run_next = s_d.ctrl.run;
    assign reload   = s_q.reload;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q,
    input  logic             run_next,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [CNT_W-1:0] reload_eff;

    assign reload_eff = (reload == '0) ? ONE : reload;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        if (run_next) begin
            if (!run_q) begin
                s_d.cnt = reload_eff;
            end else if (s_q.cnt <= ONE) begin
                s_d.fire = 1'b1;
                s_d.cnt  = reload_eff;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign fire = s_q.fire;
endmodule

// File: rtl/ivt_vecmap.sv
module ivt_vecmap
    import ivt_pkg::*;
#(
    parameter int unsigned MAP_MODE = 1
) (
    input  logic [NUM_W-1:0] num,
    input  logic [PRI_W-1:0] pri,
    output logic [NUM_W-1:0] vec
);
    generate
        if (MAP_MODE == 0) begin : g_direct
            assign vec = num;
        end else begin : g_window
            localparam logic [NUM_W-1:0] KEEP = NUM_W'(8'h3F);
            localparam logic [NUM_W-1:0] BASE = NUM_W'(8'h40);
            assign vec = (num & KEEP) | BASE | NUM_W'({pri, 2'b00});
        end
    endgenerate
endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned BUS_PERIOD_NS = 20,
    parameter int unsigned MAP_MODE      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_req,
    output logic [7:0]        irq_vec,
    output logic [3:0]        irq_pri
);
    ctrl_t            ctrl_w;
    logic             run_next_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             fire_w;

    ivt_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BUS_PERIOD_NS(BUS_PERIOD_NS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cnt(cnt_w),
        .ctrl(ctrl_w), .run_next(run_next_w), .reload(reload_w), .rdata(rdata)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_q(ctrl_w.run), .run_next(run_next_w),
        .reload(reload_w), .cnt(cnt_w), .fire(fire_w)
    );

    ivt_vecmap #(.MAP_MODE(MAP_MODE)) u_map (
        .num(ctrl_w.num), .pri(ctrl_w.pri), .vec(irq_vec)
    );

    assign irq_req = fire_w;
    assign irq_pri = ctrl_w.pri;
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned MAP_MODE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_run_bit,
    input logic              run,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  cnt,
    input logic              irq_req,
    input logic [7:0]        irq_vec
);
    logic stop_wr;
    assign stop_wr = wr_en && (addr == ADDR_W'(ivt_pkg::OFS_CTRL)) && !wr_run_bit;

    AST_FIRE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> run);  // R7
    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !irq_req);  // R7
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));  // R11
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !irq_req) |-> (cnt == $past(cnt) - CNT_W'(1)));  // R11
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cnt == (($past(reload) == '0) ? CNT_W'(1) : $past(reload))));  // R8
    AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (MAP_MODE != 0 && irq_req) |-> (irq_vec[7:6] == 2'b01));  // R9
endmodule

bind ivtimer ivt_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MAP_MODE(MAP_MODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_run_bit(wdata[ivt_pkg::EN_BIT]), .run(ctrl_w.run), .reload(reload_w),
    .cnt(cnt_w), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/tb_ivtimer.sv
`timescale 1ns/100ps
module tb_ivtimer;
    import ivt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, leg_rdata;
    logic        irq_req, leg_req;
    logic [7:0]  irq_vec, leg_vec;
    logic [3:0]  irq_pri, leg_pri;

    always #2.5 clk = ~clk;

    ivtimer #(.CNT_W(32), .ADDR_W(8), .BUS_PERIOD_NS(5), .MAP_MODE(1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec), .irq_pri(irq_pri)
    );
    ivtimer #(.CNT_W(32), .ADDR_W(8), .BUS_PERIOD_NS(5), .MAP_MODE(0)) dut_leg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(leg_rdata), .irq_req(leg_req), .irq_vec(leg_vec), .irq_pri(leg_pri)
    );

    typedef struct {
        int         cyc;
        logic [7:0] vec;
        logic [7:0] leg;
        logic [3:0] pri;
        string      tag;
    } pulse_t;
    typedef struct {
        logic [31:0] val;
        string       tag;
    } rd_t;

    pulse_t pq[$];
    rd_t    rq[$];
    pulse_t mp;
    rd_t    mr;
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ctrl_word(bit run, logic [3:0] pri, logic [7:0] num);
        return (32'(run) << 26) | (32'(pri) << 20) | (32'(num) << 12);
    endfunction

    task automatic goto(int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_at(int e, logic [7:0] a, logic [31:0] d);
        goto(e - 1);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_at(int n, logic [7:0] a, logic [31:0] exp, string tag);
        goto(n);
        rd_en = 1'b1; addr = a;
        rq.push_back('{exp, tag});
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic wr_now(logic [7:0] a, logic [31:0] d);
        wr_at(cyc + 1, a, d);
    endtask

    task automatic rd_now(logic [7:0] a, logic [31:0] exp, string tag);
        rd_at(cyc, a, exp, tag);
    endtask

    task automatic expect_irq(int c, logic [7:0] v, logic [7:0] l, logic [3:0] p, string tag);
        pq.push_back('{c, v, l, p, tag});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_en) begin
                checks++;
                if (rq.size() == 0) begin
                    fails++;
                    $display("FAIL read with no expected item: got %h expected none", rdata);
                end else begin
                    mr = rq.pop_front();
                    if (rdata !== mr.val) begin
                        fails++;
                        $display("FAIL %s: rdata=%h expected=%h", mr.tag, rdata, mr.val);
                    end
                end
            end
            while (pq.size() > 0 && pq[0].cyc < cyc) begin
                mp = pq.pop_front();
                checks++; fails++;
                $display("FAIL %s: irq_req=0 at cycle %0d expected 1", mp.tag, mp.cyc);
            end
            if (irq_req || leg_req) begin
                checks++;
                if (pq.size() > 0 && pq[0].cyc == cyc) begin
                    mp = pq.pop_front();
                    if (irq_vec !== mp.vec || leg_vec !== mp.leg || irq_pri !== mp.pri
                        || irq_req !== 1'b1 || leg_req !== 1'b1) begin
                        fails++;
                        $display("FAIL %s R9: vec=%h leg=%h pri=%h expected vec=%h leg=%h pri=%h",
                                 mp.tag, irq_vec, leg_vec, irq_pri, mp.vec, mp.leg, mp.pri);
                    end
                end else begin
                    fails++;
                    $display("FAIL R5/R7: irq_req=1 at cycle %0d expected 0", cyc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        int a;
        int f;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        checks++;
        if (irq_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: irq_req=%b expected 0", irq_req);
        end

        rd_now(OFS_CTRL, 32'h0, "R1 control after reset");
        rd_now(OFS_RELOAD, 32'h0, "R1 reload after reset");
        rd_now(OFS_COUNT, 32'h0, "R1 count after reset");
        rd_now(OFS_PERIOD, 32'd5, "R3 period register");
        wr_now(OFS_RELOAD, 32'hDEADBEEF);
        rd_now(OFS_RELOAD, 32'hDEADBEEF, "R3 reload full width");
        wr_now(OFS_PERIOD, 32'd77);
        rd_now(OFS_PERIOD, 32'd5, "R3 period write ignored");
        wr_now(OFS_CTRL, 32'hFBFF_FFFF);
        rd_now(OFS_CTRL, 32'h00FF_F000, "R2 field masking");
        rd_now(OFS_COUNT, 32'h0, "R2 not started without run bit");
        wr_now(OFS_CTRL, 32'h0);
        wr_now(OFS_RELOAD, 32'd5);

        a = cyc + 2;
        expect_irq(a + 5,  8'h5D, 8'h95, 4'h3, "R4 first expiry");
        expect_irq(a + 10, 8'h5D, 8'h95, 4'h3, "R4 second expiry");
        expect_irq(a + 15, 8'h66, 8'h22, 4'h1, "R10 no restart");
        expect_irq(a + 20, 8'h66, 8'h22, 4'h1, "R8 old interval kept");
        expect_irq(a + 23, 8'h66, 8'h22, 4'h1, "R8 new interval");
        expect_irq(a + 26, 8'h66, 8'h22, 4'h1, "R8 new interval");
        wr_at(a, OFS_CTRL, ctrl_word(1'b1, 4'h3, 8'h95));
        rd_at(a + 7, OFS_COUNT, 32'd3, "R11 count step");
        rd_at(a + 8, OFS_COUNT, 32'd2, "R11 count step");
        wr_at(a + 12, OFS_CTRL, ctrl_word(1'b1, 4'h1, 8'h22));
        wr_at(a + 17, OFS_RELOAD, 32'd3);
        rd_at(a + 18, OFS_COUNT, 32'd2, "R8 running count unchanged");
        rd_at(a + 19, OFS_RELOAD, 32'd3, "R3 reload readback");
        wr_at(a + 29, OFS_CTRL, 32'h0);
        rd_at(a + 31, OFS_COUNT, 32'd1, "R7 count held");
        rd_at(a + 32, OFS_CTRL, 32'h0, "R7 stopped");

        f = a + 64;
        wr_at(a + 62, OFS_RELOAD, 32'd0);
        for (int k = 1; k <= 4; k++)
            expect_irq(f + k, 8'h5D, 8'h95, 4'h3, "R6 zero reload");
        wr_at(f, OFS_CTRL, ctrl_word(1'b1, 4'h3, 8'h95));
        rd_at(f, OFS_COUNT, 32'd1, "R6 zero reload acts as one");
        wr_at(f + 5, OFS_CTRL, 32'h0);
        goto(f + 20);

        while (pq.size() > 0) begin
            mp = pq.pop_front();
            checks++; fails++;
            $display("FAIL %s: irq_req never seen at cycle %0d expected 1", mp.tag, mp.cyc);
        end
        summary();
    end
endmodule